// File: doc/BRIEF.md
# Strobe-Gated Burst Line Reader

This block moves one read burst from a DDR pseudo-static memory with an 8-bit data lane and a read strobe into an on-chip scan-line buffer. A separate sequencer has already issued the command and address phase before this block is started. On a start request the block takes the data lane back as an input by dropping its output enable. It produces the memory clock from a phase accumulator and waits for the read strobe to be seen high. It then writes one byte every two system clocks into the line buffer.

Each burst is exactly `BURST_LEN` bytes long. It lands in one quarter of a `4*BURST_LEN` byte buffer, chosen by the low two bits of the row number, so that four consecutive rows fill one display line. The sample point can be moved one system clock later through a parameter. An optional two-stage input register, applied alike to the strobe and to the data, delays both by two clocks. If the strobe never comes, a timeout ends the burst and pulses an error flag.

Top module: `burst_line_reader`

## Requirements
- R1: Out of reset and while idle, `dq_oe_o` is 1, `mem_clk_o` is 0, `busy_o` is 0 and `wr_en_o` is 0.
- R2: From the clock edge that accepts `start_i` until the burst ends, `busy_o` is 1 and `dq_oe_o` is 0, so the data lane is released.
- R3: `mem_clk_o` is bit 31 of a 32-bit accumulator. The accumulator is 0 after the accepting edge and adds `clk_inc_i` on every later edge while busy, so after k edges it holds k*`clk_inc_i` mod 2^32. An increment of 2^30 gives a quarter of the system rate. The clock is 0 once the burst ends.
- R4: No byte is written before the synchronized strobe is seen high. With `SAMPLE_SKEW`=0, the first write is issued 2 edges after the detecting edge.
- R5: After the first byte, one byte is written on every second edge with no gaps. `wr_data_o` is the synchronized data lane as sampled on the edge that issues the write.
- R6: Exactly `BURST_LEN` bytes are written. `done_o` pulses for one cycle together with the last write. `busy_o` and `mem_clk_o` are 0 from that edge on.
- R7: Write j of a burst (counting from 0) has address `row_sel_i`*`BURST_LEN` + j, where `row_sel_i` is the low two bits of the row number.
- R8: With `SAMPLE_SKEW`=1, every write moves one edge later: the first write is issued 3 edges after detection.
- R9: With `IN_REG`=1, both `rwds_i` and `dq_i` pass through two register stages, so each is seen two edges later than without them.
- R10: `start_i` is ignored while busy. Neither the quarter, the byte count nor the clock phase of the running burst changes.
- R11: If the strobe is not seen within `timeout_i` edges after the accepting edge, the block returns to idle and `err_o` pulses for one cycle on edge S+`timeout_i`, with no byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to start a read burst |
| row_sel_i | input | 2 | Low two bits of the row number; selects the buffer quarter |
| clk_inc_i | input | ACC_W | Phase increment for the memory clock accumulator |
| timeout_i | input | TO_W | Maximum number of edges to wait for the strobe |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse with the last byte write |
| err_o | output | 1 | One-cycle pulse when the strobe wait times out |
| dq_oe_o | output | 1 | Output enable for the data lane drivers (0 = released) |
| dq_i | input | DW | Data lane input |
| rwds_i | input | 1 | Read data strobe from the memory |
| mem_clk_o | output | 1 | Memory clock |
| wr_en_o | output | 1 | Line buffer write enable |
| wr_addr_o | output | $clog2(4*BURST_LEN) | Line buffer write address |
| wr_data_o | output | DW | Line buffer write data |

## Verification
The hardest situation to reach is a second start request arriving in the middle of a running burst. Its effect would only show as a quarter, a byte count or a clock phase that is slightly wrong. The bench drives a request with a different row while a burst is capturing, and then checks every write address, the exact edge of every write and the expected memory clock level on every busy cycle against values computed from the first request alone. Two instances, one plain and one with the sample skew and the input registers, receive the same stimulus. This shows the two-edge and one-edge shifts as arithmetic offsets in the edge count.

// File: rtl/blr_pkg.sv
package blr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_CAPT = 2'd2
   } blr_state_e;
endpackage

// File: rtl/blr_in_stage.sv
module blr_in_stage #(
   parameter int W      = 9,
   parameter bit IN_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (IN_REG) begin : g_reg
         logic [W-1:0] s1_q, s2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1_q <= '0;
               s2_q <= '0;
            end else begin
               s1_q <= d_i;
               s2_q <= s1_q;
            end
         end
         assign q_o = s2_q;
      end else begin : g_pass
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/blr_clk_gen.sv
module blr_clk_gen #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [ACC_W-1:0] inc_i,
   output logic             clk_o
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc_q <= '0;
      else if (!run_i || load_i) acc_q <= '0;
      else                       acc_q <= acc_q + inc_i;
   end

   assign clk_o = acc_q[ACC_W-1];
endmodule

// File: rtl/blr_capture.sv
module blr_capture
   import blr_pkg::*;
#(
   parameter int DW          = 8,
   parameter int BURST_LEN   = 512,
   parameter int TO_W        = 16,
   parameter bit SAMPLE_SKEW = 1'b0,
   localparam int IDX_W      = $clog2(BURST_LEN),
   localparam int ADDR_W     = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        quarter_i,
   input  logic [TO_W-1:0]   timeout_i,
   input  logic              strobe_i,
   input  logic [DW-1:0]     data_i,
   output logic              busy_o,
   output logic              run_o,
   output logic              load_o,
   output logic              done_o,
   output logic              err_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DW-1:0]     wr_data_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);
   localparam logic [1:0]       GAP_INIT = SAMPLE_SKEW ? 2'd2 : 2'd1;

   blr_state_e       state_q;
   logic [1:0]       quarter_q;
   logic [IDX_W-1:0] idx_q;
   logic [1:0]       gap_q;
   logic [TO_W-1:0]  tcnt_q;

   logic accept, finish, abort;

   always_comb begin
      accept = (state_q == ST_IDLE) && start_i;
      finish = (state_q == ST_CAPT) && (gap_q == 2'd0) && (idx_q == LAST_IDX);
      abort  = (state_q == ST_WAIT) && !strobe_i && (tcnt_q == timeout_i - 1'b1);
   end

   assign busy_o = (state_q != ST_IDLE);
   assign load_o = accept;
   assign run_o  = accept || (busy_o && !finish && !abort);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         quarter_q <= '0;
         idx_q     <= '0;
         gap_q     <= '0;
         tcnt_q    <= '0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         done_o  <= 1'b0;
         err_o   <= 1'b0;
         wr_en_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q   <= ST_WAIT;
                  quarter_q <= quarter_i;
                  idx_q     <= '0;
                  tcnt_q    <= '0;
               end
            end
            ST_WAIT: begin
               if (strobe_i) begin
                  state_q <= ST_CAPT;
                  gap_q   <= GAP_INIT;
               end else if (abort) begin
                  state_q <= ST_IDLE;
                  err_o   <= 1'b1;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            ST_CAPT: begin
               if (gap_q != 2'd0) begin
                  gap_q <= gap_q - 1'b1;
               end else begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= {quarter_q, idx_q};
                  wr_data_o <= data_i;
                  gap_q     <= 2'd1;
                  if (finish) begin
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/burst_line_reader.sv
module burst_line_reader #(
   parameter int DW          = 8,
   parameter int ACC_W       = 32,
   parameter int BURST_LEN   = 512,
   parameter int BUF_DEPTH   = 2048,
   parameter int TO_W        = 16,
   parameter bit SAMPLE_SKEW = 1'b0,
   parameter bit IN_REG      = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [1:0]                   row_sel_i,
   input  logic [ACC_W-1:0]             clk_inc_i,
   input  logic [TO_W-1:0]              timeout_i,
   output logic                         busy_o,
   output logic                         done_o,
   output logic                         err_o,
   output logic                         dq_oe_o,
   input  logic [DW-1:0]                dq_i,
   input  logic                         rwds_i,
   output logic                         mem_clk_o,
   output logic                         wr_en_o,
   output logic [$clog2(BUF_DEPTH)-1:0] wr_addr_o,
   output logic [DW-1:0]                wr_data_o
);
   localparam int ADDR_W = $clog2(BUF_DEPTH);

   generate
      if (BUF_DEPTH != 4 * BURST_LEN) begin : g_bad_depth
         $error("BUF_DEPTH must hold exactly four bursts");
      end
      if ((BURST_LEN < 2) || ((BURST_LEN & (BURST_LEN - 1)) != 0)) begin : g_bad_len
         $error("BURST_LEN must be a power of two of at least 2");
      end
      if (ACC_W < 2) begin : g_bad_acc
         $error("ACC_W must be at least 2");
      end
   endgenerate

   logic [DW:0] in_raw, in_sync;
   logic        run, load;

   assign in_raw = {rwds_i, dq_i};

   blr_in_stage #(.W(DW + 1), .IN_REG(IN_REG)) u_in (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (in_raw),
      .q_o   (in_sync)
   );

   blr_capture #(
      .DW          (DW),
      .BURST_LEN   (BURST_LEN),
      .TO_W        (TO_W),
      .SAMPLE_SKEW (SAMPLE_SKEW)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .quarter_i (row_sel_i),
      .timeout_i (timeout_i),
      .strobe_i  (in_sync[DW]),
      .data_i    (in_sync[DW-1:0]),
      .busy_o    (busy_o),
      .run_o     (run),
      .load_o    (load),
      .done_o    (done_o),
      .err_o     (err_o),
      .wr_en_o   (wr_en_o),
      .wr_addr_o (wr_addr_o[ADDR_W-1:0]),
      .wr_data_o (wr_data_o)
   );

   blr_clk_gen #(.ACC_W(ACC_W)) u_clk (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .load_i (load),
      .inc_i  (clk_inc_i),
      .clk_o  (mem_clk_o)
   );

   assign dq_oe_o = !busy_o;
endmodule

// File: rtl/blr_checker.sv
module blr_checker #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic              dq_oe_o,
   input logic              mem_clk_o,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o
);
   a_r1_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_clk_o);

   a_r2_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !dq_oe_o);

   a_r5_two_edge_cadence: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !done_o) |=> ##1 (wr_en_o && (wr_addr_o == $past(wr_addr_o, 2) + 1'b1)));

   a_r6_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (wr_en_o && !busy_o));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o);

   a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && !wr_en_o));
endmodule

bind burst_line_reader blr_checker #(.ADDR_W($clog2(BUF_DEPTH))) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o),
   .dq_oe_o   (dq_oe_o),
   .mem_clk_o (mem_clk_o),
   .wr_en_o   (wr_en_o),
   .wr_addr_o (wr_addr_o)
);

// File: tb/burst_line_reader_tb.sv
module burst_line_reader_tb;
   localparam int BL = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic        start_i = 1'b0;
   logic [1:0]  row_sel = 2'd0;
   logic [31:0] inc = 32'h4000_0000;
   logic [15:0] tmo = 16'd200;
   logic        rwds = 1'b0;
   logic [7:0]  dq = 8'h00;

   logic        busy [2], done [2], err [2], oe [2], mclk [2], wen [2];
   logic [10:0] waddr [2];
   logic [7:0]  wdata [2];

   int unsigned total = 0, bad = 0;
   bit          finished = 1'b0;

   // per-instance expectations
   bit          armed [2];
   int unsigned w0 [2];
   int unsigned wc [2];
   int unsigned base_exp;
   int unsigned s_edge;

   function automatic logic [7:0] hval(int unsigned n);
      return 8'((n * 37 + 11) ^ (n >> 3));
   endfunction

   function automatic void chk(bit ok, string req, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endfunction

   always @(negedge clk) dq <= hval(cyc);

   burst_line_reader #(.SAMPLE_SKEW(1'b0), .IN_REG(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_sel_i(row_sel),
      .clk_inc_i(inc), .timeout_i(tmo), .busy_o(busy[0]), .done_o(done[0]),
      .err_o(err[0]), .dq_oe_o(oe[0]), .dq_i(dq), .rwds_i(rwds),
      .mem_clk_o(mclk[0]), .wr_en_o(wen[0]), .wr_addr_o(waddr[0]), .wr_data_o(wdata[0])
   );

   burst_line_reader #(.SAMPLE_SKEW(1'b1), .IN_REG(1'b1)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_sel_i(row_sel),
      .clk_inc_i(inc), .timeout_i(tmo), .busy_o(busy[1]), .done_o(done[1]),
      .err_o(err[1]), .dq_oe_o(oe[1]), .dq_i(dq), .rwds_i(rwds),
      .mem_clk_o(mclk[1]), .wr_en_o(wen[1]), .wr_addr_o(waddr[1]), .wr_data_o(wdata[1])
   );

   // continuous monitor: instance 1 has skew 1 and input delay 2
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int i = 0; i < 2; i++) begin
            logic exp_clk;
            exp_clk = busy[i] ? 1'(32'((cyc - s_edge) * inc) >> 31) : 1'b0;
            chk(mclk[i] == exp_clk, "R3 memory clock", mclk[i], exp_clk);
            chk(oe[i] == !busy[i], "R2 bus release", oe[i], !busy[i]);
            if (wen[i]) begin
               chk(armed[i] && wc[i] < BL, "R6 write outside burst", wc[i], BL);
               chk(cyc == w0[i] + 2 * wc[i], (i == 0) ? "R4/R5 write edge" : "R8/R9 write edge",
                   cyc, w0[i] + 2 * wc[i]);
               chk(waddr[i] == 11'(base_exp + wc[i]), "R7 address", waddr[i], base_exp + wc[i]);
               chk(wdata[i] == hval(cyc - 1 - 2 * i), "R5 data", wdata[i], hval(cyc - 1 - 2 * i));
               chk(done[i] == (wc[i] == BL - 1), "R6 done with last", done[i], wc[i] == BL - 1);
               wc[i]++;
            end else begin
               chk(!done[i], "R6 done without write", done[i], 0);
            end
         end
      end
   end

   task automatic run_burst(input int r, input int delay, input logic [31:0] step, input bit inject);
      @(negedge clk);
      inc      = step;
      tmo      = 16'd200;
      row_sel  = 2'(r);
      start_i  = 1'b1;
      s_edge   = cyc + 1;
      base_exp = (r & 3) * BL;
      for (int i = 0; i < 2; i++) begin
         armed[i] = 1'b1; wc[i] = 0; w0[i] = 32'hFFFF_0000;
      end
      @(negedge clk);
      start_i = 1'b0;
      row_sel = 2'(r + 1);
      chk(busy[0] && busy[1] && !oe[0] && !oe[1], "R2 busy after start", busy[0], 1);
      for (int k = 1; k < delay; k++) @(negedge clk);
      rwds = 1'b1;
      w0[0] = cyc + 1 + 2;
      w0[1] = cyc + 1 + 2 + 2 + 1;
      if (inject) begin
         for (int k = 0; k < 40; k++) @(negedge clk);
         start_i = 1'b1;       // R10: must be ignored
         @(negedge clk);
         start_i = 1'b0;
      end
      while (!(wc[0] == BL && wc[1] == BL)) @(negedge clk);
      rwds = 1'b0;
      for (int k = 0; k < 6; k++) @(negedge clk);
      chk(wc[0] == BL && wc[1] == BL, "R6 exact count", wc[0] + wc[1], 2 * BL);
      chk(!busy[0] && !busy[1] && !mclk[0] && !mclk[1], "R6 idle after burst", busy[0], 0);
      if (inject) chk(!busy[0], "R10 no restart from ignored start", busy[0], 0);
      armed[0] = 1'b0; armed[1] = 1'b0;
   endtask

   task automatic run_timeout(input int t);
      @(negedge clk);
      tmo     = 16'(t);
      inc     = 32'h4000_0000;
      row_sel = 2'd1;
      start_i = 1'b1;
      s_edge  = cyc + 1;
      armed[0] = 1'b0; armed[1] = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      while (cyc != s_edge + t - 1) @(negedge clk);
      chk(busy[0] && busy[1] && !err[0] && !err[1], "R11 still waiting", err[0], 0);
      @(negedge clk);
      chk(err[0] && err[1] && !busy[0] && !busy[1], "R11 error pulse", err[0], 1);
      @(negedge clk);
      chk(!err[0] && !err[1], "R11 error one cycle", err[0], 0);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      armed[0] = 1'b0; armed[1] = 1'b0;
      wc[0] = 0; wc[1] = 0; w0[0] = 0; w0[1] = 0;
      base_exp = 0; s_edge = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int i = 0; i < 2; i++)
         chk(oe[i] && !mclk[i] && !busy[i] && !wen[i] && !done[i] && !err[i],
             "R1 reset state", {oe[i], mclk[i], busy[i], wen[i]}, 4'b1000);
      // sweep rows, strobe delays, clock increments
      for (int r = 0; r < 8; r++) begin
         logic [31:0] step;
         step = (r == 7) ? 32'h8000_0000 : (r[0] ? 32'h2000_0000 : 32'h4000_0000);
         run_burst(r, 1 + (r * 5) % 9, step, (r == 2) || (r == 5));
      end
      run_timeout(20);
      run_timeout(3);
      run_burst(3, 1, 32'h4000_0000, 1'b1);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule